// File: doc/BRIEF.md
# Machine Cycle Timing Sequencer

This block produces the internal timing of a small 8-bit processor core. One clock tick is one phase slot. A machine cycle is six states, and each state has a first phase and a second phase, so a cycle has twelve slots. The slots are numbered 0 to 11 in the order S1P1, S1P2, S2P1, …, S6P2. From its position in the cycle and the class of the current instruction, the sequencer drives these strobes: address latch enable, code fetch, external-data access window, opcode latch, second-byte latch, program counter increment and end-of-instruction.

The instruction decoder sits outside the block. It presents the class of the fetched opcode in the slot where the opcode latch strobe is high. The class gives the byte length, the cycle count and whether the instruction accesses external data memory. The sequencer captures the class at that edge and ignores the decode inputs at every other time. A down-counter of remaining machine cycles is loaded from the class and counts down once per cycle. A separate up-counting cycle index tells the strobe logic which cycle of the instruction is running.

Top module: `mcs_sequencer`

## Requirements
- R1: After synchronous reset the block is at S1P1 (state_num 0, phase_two 0) with cycle_idx 0. In that slot code_fetch is 1 and ale, xdata_strobe, opcode_latch, byte2_latch, pc_inc and done are all 0.
- R2: The position advances one phase per clock. state_num counts 0..5 with phase_two 0 then 1 in each state, and the position wraps from S6P2 (slot 11) back to S1P1.
- R3: ale is 1 in slots 1, 2, 7 and 8 (S1P2, S2P1, S4P2, S5P1) of every machine cycle, including suppressed cycles, and 0 in all other slots.
- R4: code_fetch is 1 during states S1 and S4 (slots 0, 1, 6, 7) of every machine cycle except a suppressed one, and 0 otherwise.
- R5: opcode_latch pulses for one slot at S1P2 of the first cycle of each instruction. dec_two_byte, dec_cycles and dec_xdata are captured only at that point, and later changes to them have no effect on the running instruction.
- R6: For a two-byte instruction (dec_two_byte=1), byte2_latch and pc_inc pulse at S4P2 of the first cycle. For a one-byte instruction the S4 fetch still occurs, but neither byte2_latch nor pc_inc is asserted at S4P2.
- R7: pc_inc pulses together with opcode_latch at S1P2 of the first cycle of every instruction.
- R8: done pulses for one slot at S6P2 of the last cycle of an instruction and at no other time. The next opcode_latch follows at the very next S1P2.
- R9: dec_cycles selects the instruction length: 0 gives one cycle, 1 gives two cycles, 2 gives four cycles, and the unused code 3 gives one cycle.
- R10: An external-data instruction (dec_xdata=1, one byte, dec_cycles=1) suppresses code_fetch in its second cycle. In that cycle xdata_strobe is 1 in slots 0, 1, 6 and 7 and 0 elsewhere, and xdata_strobe is 0 in every other cycle.
- R11: cycle_idx is 0 in the first cycle of an instruction and counts up by one at each cycle boundary until done.
- R12: Reset applied in the middle of a multi-cycle instruction returns the block to the R1 state. The next instruction then starts at the following S1P2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase-slot clock, one tick per phase |
| rst | input | 1 | Synchronous active-high reset |
| dec_two_byte | input | 1 | Decoded class: instruction has a second code byte |
| dec_cycles | input | 2 | Decoded class: cycle count code (0=1, 1=2, 2=4, 3=1) |
| dec_xdata | input | 1 | Decoded class: instruction accesses external data memory |
| state_num | output | 3 | Current state, 0 for S1 through 5 for S6 |
| phase_two | output | 1 | 0 in the first phase of a state, 1 in the second |
| cycle_idx | output | 2 | Machine cycle number within the current instruction |
| ale | output | 1 | Address latch enable |
| code_fetch | output | 1 | Code memory read strobe |
| xdata_strobe | output | 1 | External data memory access window |
| opcode_latch | output | 1 | Load the instruction register |
| byte2_latch | output | 1 | Keep the second code byte |
| pc_inc | output | 1 | Advance the program counter |
| done | output | 1 | Last slot of the instruction |

## Verification
The assertions assume the decoder presents a legal class while opcode_latch is high: an external-data instruction must also be one byte long and two cycles long. The block does not check this itself. Apart from that slot, the assertions make no assumption about the decode inputs. The stimulus uses the external-data flag only with that combination, and uses the unused cycle code only for ordinary instructions. It also deliberately drives inverted decode values after the capture slot, to show that the block ignores them there.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int NUM_STATES   = 6;
    localparam int SLOTS        = 2 * NUM_STATES;
    localparam int MAX_CYCLES   = 4;
    localparam int CYC_W        = $clog2(MAX_CYCLES);

    // slots whose placement is behaviour
    localparam int SLOT_OPCODE  = 1;   // S1P2
    localparam int SLOT_BYTE2   = 7;   // S4P2
    localparam int STATE_FETCH_A = 0;  // S1
    localparam int STATE_FETCH_B = 3;  // S4

    typedef enum logic [1:0] {
        CYC_ONE  = 2'd0,
        CYC_TWO  = 2'd1,
        CYC_FOUR = 2'd2,
        CYC_RSV  = 2'd3
    } cyc_code_e;

    typedef struct packed {
        logic      two_byte;
        cyc_code_e cycles;
        logic      xdata;
    } instr_class_t;

    typedef struct packed {
        logic ale;
        logic code_fetch;
        logic xdata_strobe;
        logic opcode_latch;
        logic byte2_latch;
        logic pc_inc;
    } strobes_t;

    function automatic logic [CYC_W-1:0] cycles_minus_one(input cyc_code_e c);
        case (c)
            CYC_TWO:  return CYC_W'(1);
            CYC_FOUR: return CYC_W'(3);
            default:  return '0;
        endcase
    endfunction

    function automatic logic in_ale_window(input int s);
        return (s == 1) || (s == 2) || (s == 7) || (s == 8);
    endfunction

    function automatic logic in_fetch_window(input int s);
        return ((s / 2) == STATE_FETCH_A) || ((s / 2) == STATE_FETCH_B);
    endfunction

endpackage

// File: rtl/mcs_phase_ctr.sv
module mcs_phase_ctr #(
    parameter int NUM_STATES = mcs_pkg::NUM_STATES,
    localparam int SLOTS     = 2 * NUM_STATES,
    localparam int SLOT_W    = $clog2(SLOTS),
    localparam int STATE_W   = $clog2(NUM_STATES)
) (
    input  logic               clk,
    input  logic               rst,
    output logic [SLOT_W-1:0]  slot,
    output logic [STATE_W-1:0] state_num,
    output logic               phase_two,
    output logic               cycle_end
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (slot == LAST)
            slot <= '0;
        else
            slot <= slot + SLOT_W'(1);
    end

    assign state_num = STATE_W'(slot >> 1);
    assign phase_two = slot[0];
    assign cycle_end = (slot == LAST);

    a_r2_slot_step: assert property (@(posedge clk) disable iff (rst)
        (slot != LAST) |=> (slot == $past(slot) + SLOT_W'(1)));

    a_r2_slot_wrap: assert property (@(posedge clk) disable iff (rst)
        cycle_end |=> (slot == '0));

endmodule

// File: rtl/mcs_instr_track.sv
module mcs_instr_track
    import mcs_pkg::*;
#(
    parameter int MAX_CYC = mcs_pkg::MAX_CYCLES,
    localparam int CNT_W  = $clog2(MAX_CYC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             cycle_end,
    input  instr_class_t     dec_class,
    output logic             cls_two_byte,
    output logic             cls_xdata,
    output logic [CNT_W-1:0] cyc_idx,
    output logic             instr_done
);

    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_two_byte <= 1'b0;
            cls_xdata    <= 1'b0;
            remaining    <= '0;
        end else if (load) begin
            cls_two_byte <= dec_class.two_byte;
            cls_xdata    <= dec_class.xdata;
            remaining    <= CNT_W'(cycles_minus_one(dec_class.cycles));
        end else if (cycle_end && (remaining != '0)) begin
            remaining    <= remaining - CNT_W'(1);
        end
    end

    assign instr_done = cycle_end && (remaining == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cyc_idx <= '0;
        else if (instr_done)
            cyc_idx <= '0;
        else if (cycle_end)
            cyc_idx <= cyc_idx + CNT_W'(1);
    end

    a_r8_done_restart: assert property (@(posedge clk) disable iff (rst)
        instr_done |=> (cyc_idx == '0));

    a_r9_count_down: assert property (@(posedge clk) disable iff (rst)
        (cycle_end && (remaining != '0)) |=> (remaining == $past(remaining) - CNT_W'(1)));

    a_r11_idx_step: assert property (@(posedge clk) disable iff (rst)
        (cycle_end && !instr_done) |=> (cyc_idx == $past(cyc_idx) + CNT_W'(1)));

endmodule

// File: rtl/mcs_strobe_gen.sv
module mcs_strobe_gen
    import mcs_pkg::*;
#(
    parameter int SLOT_W = 4,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] slot,
    input  logic [CNT_W-1:0]  cyc_idx,
    input  logic              cls_two_byte,
    input  logic              cls_xdata,
    output strobes_t          stb
);

    logic first_cycle;
    logic suppressed;
    logic fetch_win;

    assign first_cycle = (cyc_idx == '0);
    assign suppressed  = cls_xdata && (cyc_idx == CNT_W'(1));
    assign fetch_win   = in_fetch_window(int'(slot));

    always_comb begin
        stb              = '0;
        stb.ale          = in_ale_window(int'(slot));
        stb.code_fetch   = fetch_win && !suppressed;
        stb.xdata_strobe = fetch_win && suppressed;
        stb.opcode_latch = first_cycle && (int'(slot) == SLOT_OPCODE);
        stb.byte2_latch  = first_cycle && cls_two_byte && (int'(slot) == SLOT_BYTE2);
        stb.pc_inc       = stb.opcode_latch || stb.byte2_latch;
    end

    a_r4_fetch_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(stb.code_fetch && stb.xdata_strobe));

    a_r10_xdata_second_only: assert property (@(posedge clk) disable iff (rst)
        stb.xdata_strobe |-> (cyc_idx == CNT_W'(1)));

    a_r6_byte2_advances_pc: assert property (@(posedge clk) disable iff (rst)
        stb.byte2_latch |-> stb.pc_inc);

endmodule

// File: rtl/mcs_sequencer.sv
module mcs_sequencer
    import mcs_pkg::*;
#(
    parameter int NUM_ST  = mcs_pkg::NUM_STATES,
    parameter int MAX_CYC = mcs_pkg::MAX_CYCLES,
    localparam int SLOT_W  = $clog2(2 * NUM_ST),
    localparam int STATE_W = $clog2(NUM_ST),
    localparam int CNT_W   = $clog2(MAX_CYC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dec_two_byte,
    input  logic [1:0]         dec_cycles,
    input  logic               dec_xdata,
    output logic [STATE_W-1:0] state_num,
    output logic               phase_two,
    output logic [CNT_W-1:0]   cycle_idx,
    output logic               ale,
    output logic               code_fetch,
    output logic               xdata_strobe,
    output logic               opcode_latch,
    output logic               byte2_latch,
    output logic               pc_inc,
    output logic               done
);

    logic [SLOT_W-1:0] slot;
    logic              cycle_end;
    logic              cls_two_byte;
    logic              cls_xdata;
    instr_class_t      dec_class;
    strobes_t          stb;

    assign dec_class.two_byte = dec_two_byte;
    assign dec_class.cycles   = cyc_code_e'(dec_cycles);
    assign dec_class.xdata    = dec_xdata;

    mcs_phase_ctr #(.NUM_STATES(NUM_ST)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .slot      (slot),
        .state_num (state_num),
        .phase_two (phase_two),
        .cycle_end (cycle_end)
    );

    mcs_instr_track #(.MAX_CYC(MAX_CYC)) u_track (
        .clk          (clk),
        .rst          (rst),
        .load         (stb.opcode_latch),
        .cycle_end    (cycle_end),
        .dec_class    (dec_class),
        .cls_two_byte (cls_two_byte),
        .cls_xdata    (cls_xdata),
        .cyc_idx      (cycle_idx),
        .instr_done   (done)
    );

    mcs_strobe_gen #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_strobe (
        .clk          (clk),
        .rst          (rst),
        .slot         (slot),
        .cyc_idx      (cycle_idx),
        .cls_two_byte (cls_two_byte),
        .cls_xdata    (cls_xdata),
        .stb          (stb)
    );

    assign ale          = stb.ale;
    assign code_fetch   = stb.code_fetch;
    assign xdata_strobe = stb.xdata_strobe;
    assign opcode_latch = stb.opcode_latch;
    assign byte2_latch  = stb.byte2_latch;
    assign pc_inc       = stb.pc_inc;

    // input assumption: decoder gives a legal class for external data access
    a_r10_dec_legal: assert property (@(posedge clk) disable iff (rst)
        (opcode_latch && dec_xdata) |-> (dec_cycles == 2'd1 && !dec_two_byte));

    a_r3_ale_rises_in_phase_two: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |-> phase_two);

    a_r5_latch_under_ale: assert property (@(posedge clk) disable iff (rst)
        opcode_latch |-> (ale && code_fetch));

    a_r8_latch_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !opcode_latch ##1 opcode_latch);

endmodule

// File: tb/mcs_sequencer_tb.sv
module mcs_sequencer_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       dec_two_byte;
    logic [1:0] dec_cycles;
    logic       dec_xdata;
    logic [2:0] state_num;
    logic       phase_two;
    logic [1:0] cycle_idx;
    logic       ale, code_fetch, xdata_strobe, opcode_latch, byte2_latch, pc_inc, done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mcs_sequencer u_dut (
        .clk(clk), .rst(rst),
        .dec_two_byte(dec_two_byte), .dec_cycles(dec_cycles), .dec_xdata(dec_xdata),
        .state_num(state_num), .phase_two(phase_two), .cycle_idx(cycle_idx),
        .ale(ale), .code_fetch(code_fetch), .xdata_strobe(xdata_strobe),
        .opcode_latch(opcode_latch), .byte2_latch(byte2_latch),
        .pc_inc(pc_inc), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " R1 state_num"}, state_num, 0);
        chk({tag, " R1 phase_two"}, phase_two, 0);
        chk({tag, " R1 cycle_idx"}, cycle_idx, 0);
        chk({tag, " R1 code_fetch"}, code_fetch, 1);
        chk({tag, " R1 quiet strobes"},
            {ale, xdata_strobe, opcode_latch, byte2_latch, pc_inc, done}, 0);
    endtask

    // Entered just after a falling edge with the DUT at slot 0 of an instruction.
    task automatic run_instr(input string name, input logic tb2, input logic [1:0] cc,
                             input logic xd);
        int ncyc;
        ncyc = (cc == 2'd1) ? 2 : (cc == 2'd2) ? 4 : 1;   // R9
        dec_two_byte = tb2;
        dec_cycles   = cc;
        dec_xdata    = xd;
        for (int c = 0; c < ncyc; c++) begin
            for (int s = 0; s < 12; s++) begin
                bit supp, fwin, op, b2;
                supp = xd && (c == 1);
                fwin = (s / 2 == 0) || (s / 2 == 3);
                op   = (c == 0) && (s == 1);
                b2   = (c == 0) && (s == 7) && tb2;
                chk({name, " R2 state_num"}, state_num, s / 2);
                chk({name, " R2 phase_two"}, phase_two, s % 2);
                chk({name, " R11 cycle_idx"}, cycle_idx, c);
                chk({name, " R3 ale"}, ale, int'(s == 1 || s == 2 || s == 7 || s == 8));
                chk({name, " R4 code_fetch"}, code_fetch, int'(fwin && !supp));
                chk({name, " R10 xdata_strobe"}, xdata_strobe, int'(fwin && supp));
                chk({name, " R5 opcode_latch"}, opcode_latch, int'(op));
                chk({name, " R6 byte2_latch"}, byte2_latch, int'(b2));
                chk({name, " R7 pc_inc"}, pc_inc, int'(op || b2));
                chk({name, " R8 done"}, done, int'((c == ncyc - 1) && (s == 11)));
                if (c == 0 && s == 2) begin
                    // R5: decode inputs after capture must be ignored
                    dec_two_byte = ~tb2;
                    dec_cycles   = ~cc;
                    dec_xdata    = 1'b0;
                end
                @(negedge clk);
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic test_mid_reset();
        dec_two_byte = 1'b1;
        dec_cycles   = 2'd2;
        dec_xdata    = 1'b0;
        repeat (29) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_reset_state("R12 mid reset");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        dec_two_byte = 1'b0;
        dec_cycles   = 2'd0;
        dec_xdata    = 1'b0;
        do_reset();
        check_reset_state("R1 after reset");
        run_instr("one-byte one-cycle", 1'b0, 2'd0, 1'b0);
        run_instr("two-byte one-cycle", 1'b1, 2'd0, 1'b0);
        run_instr("one-byte two-cycle", 1'b0, 2'd1, 1'b0);
        run_instr("two-byte four-cycle", 1'b1, 2'd2, 1'b0);
        run_instr("external data", 1'b0, 2'd1, 1'b1);
        run_instr("R9 reserved code", 1'b1, 2'd3, 1'b0);
        run_instr("one-byte four-cycle", 1'b0, 2'd2, 1'b0);
        run_instr("external data again", 1'b0, 2'd1, 1'b1);
        test_mid_reset();
        run_instr("R12 after mid reset", 1'b0, 2'd0, 1'b0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule